// File: doc/BRIEF.md
# Dual-Port Hardware Spinlock Bank

This block gives two processor cores a set of hardware mutual-exclusion flags. Each of the 32 flags sits behind its own word address. A core takes a flag by reading that word. The read is an indivisible test-and-set: when the flag was free, the read returns a nonzero token and the flag becomes held. When the flag was already held, the read returns zero and nothing changes. A core gives a flag back by writing any value to the same word. A separate status word reports the held state of every flag at once, and reading it changes nothing.

Each core has its own simple register port: a word address, a read strobe and a write strobe, plus a registered read-data output. The address is a word index. Word n selects flag n, which sits at byte offset 4n on a byte-addressed system bus. Both ports may hit the same flag in the same cycle. The bank resolves every such collision in one cycle, so two cores never both own a flag. A global clear input frees every flag at once.

Top module: `spinlock_bank`

## Requirements
- R1: After reset every flag is free, both read-data outputs are zero and the status word reads zero.
- R2: A read strobe at word address n (0 to 31) on a free flag n makes the flag held, and the next cycle's read data is 1 shifted left by n.
- R3: A read strobe at word address n on a flag that is already held returns zero and leaves all flags unchanged.
- R4: A write strobe at word address n frees flag n, whatever the write would carry. A write to a flag that is already free changes nothing.
- R5: A read at word address 32 returns the status word, in which bit n is 1 exactly when flag n was held at the start of that cycle. The read claims or frees nothing.
- R6: When both ports read the same free flag in the same cycle, port 0 receives 1 shifted left by n and port 1 receives zero. When the two ports read different free flags in the same cycle, both succeed.
- R7: A write that frees flag n and a read that claims flag n in the same cycle, on either port, act release first: the claim succeeds and the flag stays held.
- R8: Asserting clear_all frees every flag by the next cycle. A claim in that same cycle returns zero and takes nothing.
- R9: Reads and writes at word addresses 33 to 63 return zero and change no flag.
- R10: Read data is registered. It appears in the cycle after the read strobe and is zero after any cycle without a read strobe on that port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_all | input | 1 | Frees every flag in one cycle |
| p0_addr | input | 6 | Port 0 word address |
| p0_rd | input | 1 | Port 0 read strobe (claims a flag) |
| p0_wr | input | 1 | Port 0 write strobe (frees a flag) |
| p0_rdata | output | 32 | Port 0 registered read data |
| p1_addr | input | 6 | Port 1 word address |
| p1_rd | input | 1 | Port 1 read strobe (claims a flag) |
| p1_wr | input | 1 | Port 1 write strobe (frees a flag) |
| p1_rdata | output | 32 | Port 1 registered read data |

## Verification
The hardest states to reach from the ports are the collisions inside a single cycle. In one, both ports claim the same free flag. In the other, one port frees a flag while the other claims it. Both need exact, cycle-aligned strobes on the two ports, with the flag already in the right state. The bench drives both ports from one step task, so every collision is set up in a single cycle. It sweeps each collision over all 32 flags, in both port orders, after a claim step has put the flag in the needed state. A model in the bench works out the release-first and port-0-first outcome for every step.

// File: rtl/spinlock_pkg.sv
package spinlock_pkg;
  typedef enum logic [1:0] {
    AREA_NONE   = 2'd0,
    AREA_LOCK   = 2'd1,
    AREA_STATUS = 2'd2
  } area_e;

  localparam int unsigned PORTS = 2;
endpackage

// File: rtl/spl_port_decode.sv
module spl_port_decode
  import spinlock_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 6,
  localparam int unsigned IDX_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd,
  input  logic                 wr,
  output area_e                area,
  output logic [IDX_W-1:0]     idx,
  output logic [NUM_LOCKS-1:0] claim_mask,
  output logic [NUM_LOCKS-1:0] release_mask
);
  localparam logic [ADDR_W-1:0] STAT_WORD = ADDR_W'(NUM_LOCKS);

  function automatic area_e classify(input logic [ADDR_W-1:0] w);
    if (w < STAT_WORD)       return AREA_LOCK;
    else if (w == STAT_WORD) return AREA_STATUS;
    else                     return AREA_NONE;
  endfunction

  function automatic logic [NUM_LOCKS-1:0] one_flag(input logic [IDX_W-1:0] i);
    logic [NUM_LOCKS-1:0] m;
    m    = '0;
    m[i] = 1'b1;
    return m;
  endfunction

  always_comb begin
    area         = classify(addr);
    idx          = addr[IDX_W-1:0];
    claim_mask   = (rd && area == AREA_LOCK) ? one_flag(idx) : '0;
    release_mask = (wr && area == AREA_LOCK) ? one_flag(idx) : '0;
  end
endmodule

// File: rtl/spl_arbiter.sv
module spl_arbiter #(
  parameter int unsigned NUM_LOCKS = 32
) (
  input  logic [NUM_LOCKS-1:0] held_q,
  input  logic [NUM_LOCKS-1:0] rel_mask,
  input  logic [NUM_LOCKS-1:0] claim0,
  input  logic [NUM_LOCKS-1:0] claim1,
  input  logic                 clear_all,
  output logic [NUM_LOCKS-1:0] grant0,
  output logic [NUM_LOCKS-1:0] grant1
);
  logic [NUM_LOCKS-1:0] free_now;

  always_comb begin
    // release acts before claim in the same cycle
    free_now = ~(held_q & ~rel_mask);
    grant0   = clear_all ? '0 : (claim0 & free_now);
    // port 0 has fixed priority over port 1
    grant1   = clear_all ? '0 : (claim1 & free_now & ~grant0);
  end
endmodule

// File: rtl/spl_flags.sv
module spl_flags #(
  parameter int unsigned NUM_LOCKS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_all,
  input  logic [NUM_LOCKS-1:0] rel_mask,
  input  logic [NUM_LOCKS-1:0] set_mask,
  output logic [NUM_LOCKS-1:0] held_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)         held_q <= '0;
    else if (clear_all) held_q <= '0;
    else                held_q <= (held_q & ~rel_mask) | set_mask;
  end

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> held_q == '0);

  // R2
  rise_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((held_q & ~$past(held_q) & ~$past(set_mask)) == '0));

  // R4
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rel_mask & ~set_mask) != '0) |=> ((held_q & $past(rel_mask & ~set_mask)) == '0));
endmodule

// File: rtl/spinlock_bank.sv
module spinlock_bank
  import spinlock_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 6,
  localparam int unsigned IDX_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_all,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic              p0_rd,
  input  logic              p0_wr,
  output logic [DATA_W-1:0] p0_rdata,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic              p1_rd,
  input  logic              p1_wr,
  output logic [DATA_W-1:0] p1_rdata
);
  logic [ADDR_W-1:0]    addr_a    [PORTS];
  logic                 rd_a      [PORTS];
  logic                 wr_a      [PORTS];
  area_e                area_a    [PORTS];
  logic [IDX_W-1:0]     idx_a     [PORTS];
  logic [NUM_LOCKS-1:0] claim_a   [PORTS];
  logic [NUM_LOCKS-1:0] release_a [PORTS];
  logic [NUM_LOCKS-1:0] grant_a   [PORTS];
  logic [DATA_W-1:0]    rdata_q   [PORTS];
  logic [NUM_LOCKS-1:0] rel_mask;
  logic [NUM_LOCKS-1:0] held_q;

  function automatic logic [DATA_W-1:0] token(input logic [IDX_W-1:0] i);
    logic [DATA_W-1:0] t;
    t    = '0;
    t[i] = 1'b1;
    return t;
  endfunction

  assign addr_a[0] = p0_addr;
  assign rd_a[0]   = p0_rd;
  assign wr_a[0]   = p0_wr;
  assign addr_a[1] = p1_addr;
  assign rd_a[1]   = p1_rd;
  assign wr_a[1]   = p1_wr;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    spl_port_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_dec (
      .addr         (addr_a[p]),
      .rd           (rd_a[p]),
      .wr           (wr_a[p]),
      .area         (area_a[p]),
      .idx          (idx_a[p]),
      .claim_mask   (claim_a[p]),
      .release_mask (release_a[p])
    );

    always_ff @(posedge clk) begin
      if (!rst_n || !rd_a[p]) begin
        rdata_q[p] <= '0;
      end else begin
        unique case (area_a[p])
          AREA_LOCK:   rdata_q[p] <= grant_a[p][idx_a[p]] ? token(idx_a[p]) : '0;
          AREA_STATUS: rdata_q[p] <= DATA_W'(held_q);
          default:     rdata_q[p] <= '0;
        endcase
      end
    end
  end

  assign rel_mask = release_a[0] | release_a[1];

  spl_arbiter #(.NUM_LOCKS(NUM_LOCKS)) u_arb (
    .held_q    (held_q),
    .rel_mask  (rel_mask),
    .claim0    (claim_a[0]),
    .claim1    (claim_a[1]),
    .clear_all (clear_all),
    .grant0    (grant_a[0]),
    .grant1    (grant_a[1])
  );

  spl_flags #(.NUM_LOCKS(NUM_LOCKS)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (clear_all),
    .rel_mask  (rel_mask),
    .set_mask  (grant_a[0] | grant_a[1]),
    .held_q    (held_q)
  );

  assign p0_rdata = rdata_q[0];
  assign p1_rdata = rdata_q[1];

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !p0_rd |=> p0_rdata == '0);

  // R6
  tie_port1_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_rd && p1_rd && p0_addr == p1_addr && area_a[0] == AREA_LOCK) |=> p1_rdata == '0);

  // R3
  held_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_rd && area_a[1] == AREA_LOCK && held_q[idx_a[1]] && !rel_mask[idx_a[1]])
      |=> p1_rdata == '0);

  // R9
  outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_rd && area_a[0] == AREA_NONE) |=> p0_rdata == '0);

  // R5
  status_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_rd && area_a[0] == AREA_STATUS) |=> p0_rdata == DATA_W'($past(held_q)));
endmodule

// File: tb/spinlock_bank_test.sv
module spinlock_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear_all = 1'b0;
  logic [5:0]  p0_addr = '0, p1_addr = '0;
  logic        p0_rd = 1'b0, p0_wr = 1'b0, p1_rd = 1'b0, p1_wr = 1'b0;
  logic [31:0] p0_rdata, p1_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  logic [31:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spinlock_bank uut (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
    .p0_addr(p0_addr), .p0_rd(p0_rd), .p0_wr(p0_wr), .p0_rdata(p0_rdata),
    .p1_addr(p1_addr), .p1_rd(p1_rd), .p1_wr(p1_wr), .p1_rdata(p1_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // 1 = flag word, 2 = status word, 0 = outside
  function automatic int kind(input logic [5:0] a);
    if (a < 6'd32) return 1;
    if (a == 6'd32) return 2;
    return 0;
  endfunction

  task automatic step(input logic r0, input logic w0, input logic [5:0] a0,
                      input logic r1, input logic w1, input logic [5:0] a1,
                      input logic clr, input string tag);
    logic [31:0] freed, g0, g1, e0, e1;
    freed = model;
    if (w0 && kind(a0) == 1) freed[a0[4:0]] = 1'b0;
    if (w1 && kind(a1) == 1) freed[a1[4:0]] = 1'b0;
    g0 = '0; g1 = '0; e0 = '0; e1 = '0;
    if (r0 && kind(a0) == 2) e0 = model;
    if (r1 && kind(a1) == 2) e1 = model;
    if (r0 && kind(a0) == 1 && !clr && !freed[a0[4:0]]) begin
      g0 = 32'd1 << a0[4:0];
      e0 = g0;
    end
    if (r1 && kind(a1) == 1 && !clr && !freed[a1[4:0]] && (g0 & (32'd1 << a1[4:0])) == 0) begin
      g1 = 32'd1 << a1[4:0];
      e1 = g1;
    end
    @(negedge clk);
    p0_rd = r0; p0_wr = w0; p0_addr = a0;
    p1_rd = r1; p1_wr = w1; p1_addr = a1;
    clear_all = clr;
    @(posedge clk);
    #1;
    p0_rd = 0; p0_wr = 0; p1_rd = 0; p1_wr = 0; clear_all = 0;
    model = clr ? '0 : (freed | g0 | g1);
    check({tag, " port0"}, p0_rdata, e0);
    check({tag, " port1"}, p1_rdata, e1);
  endtask

  task automatic status_is(input logic [31:0] exp, input string tag);
    step(1, 0, 6'd32, 0, 0, 6'd0, 0, tag);
    check({tag, " status"}, p0_rdata, exp);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog actual expired expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset p0", p0_rdata, 32'd0);
    check("R1 reset p1", p1_rdata, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    status_is(32'd0, "R1");

    // R2: claim every flag from port 0
    for (int n = 0; n < 32; n++) step(1, 0, 6'(n), 0, 0, 6'd0, 0, "R2 claim");
    // R5: status twice, no side effect
    status_is(32'hFFFF_FFFF, "R5 first");
    status_is(32'hFFFF_FFFF, "R5 second");
    // R3: held flags refuse port 1
    for (int n = 0; n < 32; n++) step(0, 0, 6'd0, 1, 0, 6'(n), 0, "R3 held");
    status_is(32'hFFFF_FFFF, "R3 unchanged");
    // R10: no read gives zero
    step(0, 0, 6'd0, 0, 0, 6'd0, 0, "R10 idle");
    // R4: free even flags from port 0, odd from port 1
    for (int n = 0; n < 32; n += 2) step(0, 1, 6'(n), 0, 0, 6'd0, 0, "R4 release");
    status_is(32'hAAAA_AAAA, "R4 half");
    for (int n = 1; n < 32; n += 2) step(0, 0, 6'd0, 0, 1, 6'(n), 0, "R4 release");
    step(0, 1, 6'd5, 0, 1, 6'd9, 0, "R4 free again");
    status_is(32'd0, "R4 empty");
    // R6: same flag on both ports
    for (int n = 0; n < 32; n++) step(1, 0, 6'(n), 1, 0, 6'(n), 0, "R6 tie");
    status_is(32'hFFFF_FFFF, "R6 tie");
    // R8: clear with a claim in the same cycle
    step(1, 0, 6'd4, 1, 0, 6'd32, 1, "R8 clear");
    status_is(32'd0, "R8 cleared");
    step(1, 0, 6'd7, 0, 0, 6'd0, 1, "R8 claim during clear");
    status_is(32'd0, "R8 nothing taken");
    // R6: different free flags both succeed
    for (int n = 0; n < 16; n++) step(1, 0, 6'(n), 1, 0, 6'(31 - n), 0, "R6 distinct");
    status_is(32'hFFFF_FFFF, "R6 distinct");
    // R7: release and claim of same flag in one cycle, both orders
    for (int n = 0; n < 32; n++) step(0, 1, 6'(n), 1, 0, 6'(n), 0, "R7 p0 frees p1 claims");
    for (int n = 0; n < 32; n++) step(1, 0, 6'(n), 0, 1, 6'(n), 0, "R7 p1 frees p0 claims");
    status_is(32'hFFFF_FFFF, "R7 held");
    step(0, 0, 6'd0, 0, 0, 6'd0, 1, "R8 clear again");
    // R9: outside words, with flags 3 and 20 held
    step(1, 0, 6'd3, 1, 0, 6'd20, 0, "R9 setup");
    for (int a = 33; a < 64; a++) step(1, 1, 6'(a), 1, 1, 6'(a), 0, "R9 outside");
    status_is(32'h0010_0008, "R9 unchanged");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule